// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It keeps a stream of 32-bit trace words in an on-chip RAM that is used as a ring. A valid/ready input delivers the words. While capture runs, each accepted word is written at the write pointer, and the pointer wraps at the end of the RAM. A sticky full flag records that the ring has wrapped since capture last started. Capture can end in three ways: firmware clears the enable, a post-trigger word budget runs out, or a manual flush is requested with stop-on-flush selected. In every case the block first pads the current four-word frame with zero words, so the write pointer stops on a frame boundary. Firmware can then poll a stopped bit.

Firmware reaches everything through a simple register bus with a 12-bit byte address. A write-data register stores a word at the write pointer and advances it, which also lets firmware clear the RAM. A read-data register returns the word at the read pointer and advances that pointer, so firmware can drain the ring. Both pointers can be read and written directly. The input stream is never stalled: words that arrive while capture is not running are accepted and dropped.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, these registers read as follows: offset 0x004 (depth) reads the RAM depth in words (256 by default, bit 31 clear); status (0x00C), capture control (0x020), flush control (0x304) and write pointer (0x018) read 0; flush status (0x300) reads 0x2 (bit 1 = stopped).
- R2: A write to 0x024 stores the write data at the write pointer and advances the pointer by one, wrapping from depth-1 to 0.
- R3: A read of 0x010 returns the word at the read pointer and advances the pointer by one, wrapping at the depth. Offsets 0x014 (read pointer) and 0x018 (write pointer) take log2(depth) low bits on write, and their upper bits read 0.
- R4: Writing 1 to bit 0 of 0x020 while stopped starts capture. It clears the full flag and sets flush status bit 1 to 0. Each cycle with trace valid high then stores the trace word at the write pointer and advances it. The trace ready output is always 1.
- R5: Status bit 0 (full) becomes 1 when any write wraps the write pointer from depth-1 to 0, and stays 1 until capture next starts.
- R6: Writing 0 to bit 0 of 0x020 during capture stops it. First, zero words are written until the write pointer is a multiple of 4. Then flush status bit 1 reads 1. If the pointer is already aligned, no word is written.
- R7: Trace words that arrive while stopped are discarded: the write pointer and the RAM contents are unchanged.
- R8: The trigger count sits at 0x01C. When flush control bit 13 (stop-on-trigger) is set, a trigger pulse during capture stores the word of that cycle and then N further words, where N is the trigger count. Capture then pads to a frame boundary and stops. When bit 13 is clear, a trigger has no effect. Bits 0, 12 and 13 of flush control read back as written.
- R9: Writing 1 to flush control bit 6 while bit 12 is clear pads the current frame with zero words. Capture then continues, and bit 6 reads 0 once the flush has completed.
- R10: Writing 1 to flush control bit 6 with bit 12 (stop-on-flush) set pads to a frame boundary and stops capture. Bit 6 then reads 0 and flush status bit 1 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered register read data |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger event pulse |
| trc_ready | output | 1 | Trace ready, constantly high |

## Verification
The hardest case to reach is the end of a triggered capture. The stop has to land on an exact word count while the input has gaps and keeps arriving after the budget runs out, and the pointer is not frame-aligned at that moment, so padding must follow. The stimulus streams random words with random idle cycles and raises the trigger on a chosen word. It keeps sending long after the budget is spent. A bench model decides which words are stored, adds the zero padding, and compares the ring contents word by word through the read-data port. A separate capture starts near the top of the ring so that the pointer wraps mid-stream, and flushes are requested at unaligned pointers with and without stop-on-flush.

// File: rtl/trs_pkg.sv
package trs_pkg;

  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_DEPTH = 12'h004;
  localparam logic [REG_AW-1:0] OFS_STAT  = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_RDAT  = 12'h010;
  localparam logic [REG_AW-1:0] OFS_RPTR  = 12'h014;
  localparam logic [REG_AW-1:0] OFS_WPTR  = 12'h018;
  localparam logic [REG_AW-1:0] OFS_TCNT  = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h020;
  localparam logic [REG_AW-1:0] OFS_WDAT  = 12'h024;
  localparam logic [REG_AW-1:0] OFS_FSTAT = 12'h300;
  localparam logic [REG_AW-1:0] OFS_FCTRL = 12'h304;

  localparam int unsigned BIT_FMT     = 0;
  localparam int unsigned BIT_FLUSH   = 6;
  localparam int unsigned BIT_STOP_FL = 12;
  localparam int unsigned BIT_STOP_TR = 13;
  localparam int unsigned BIT_STOPPED = 1;

  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_PAD   = 2'd3
  } cap_state_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_fctrl;
    logic wr_tcnt;
    logic wr_wptr;
    logic wr_rptr;
    logic wr_wdat;
    logic rd_rdat;
  } bus_cmd_t;

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign q = mem[raddr];

endmodule

// File: rtl/trs_ptrs.sv
module trs_ptrs #(
  parameter int DEPTH = 256,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_load,
  input  logic [PW-1:0] wp_val,
  input  logic          wr_adv,
  input  logic          rp_load,
  input  logic [PW-1:0] rp_val,
  input  logic          rd_adv,
  input  logic          start,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr_d, rd_ptr_d;
  logic          full_d, wrap;

  always_comb begin
    wrap = wr_adv && !wp_load && (wr_ptr == LAST);

    wr_ptr_d = wr_ptr;
    if (wp_load) begin
      wr_ptr_d = wp_val;
    end else if (wr_adv) begin
      wr_ptr_d = wr_ptr + 1'b1;
    end

    rd_ptr_d = rd_ptr;
    if (rp_load) begin
      rd_ptr_d = rp_val;
    end else if (rd_adv) begin
      rd_ptr_d = rd_ptr + 1'b1;
    end

    full_d = full;
    if (start) begin
      full_d = 1'b0;
    end else if (wrap) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (wp_load || wr_adv) wr_ptr <= wr_ptr_d;
      if (rp_load || rd_adv) rd_ptr <= rd_ptr_d;
      if (start || wrap)     full   <= full_d;
    end
  end

endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int TRG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_cmd_t         cmd,
  input  logic [TRG_W-1:0] wdata,
  input  logic             trc_valid,
  input  logic             trc_trigger,
  input  logic             aligned,
  output logic             start,
  output logic             cap_wr,
  output logic             pad_wr,
  output logic             stopped,
  output logic             cap_en,
  output logic             fmt_en,
  output logic             stop_fl,
  output logic             stop_tr,
  output logic             flush_pend,
  output logic             flush_set,
  output logic [TRG_W-1:0] tcnt
);

  cap_state_e       state_q, state_d;
  logic             cap_en_d, fmt_d, stop_fl_d, stop_tr_d, flush_d;
  logic [TRG_W-1:0] tcnt_d, rem_q, rem_d;
  logic             trig_q, trig_d;
  logic             stop_req, trig_done, flush_done;

  always_comb begin
    start      = cmd.wr_ctrl && wdata[0] && (state_q == ST_STOP);
    stop_req   = cmd.wr_ctrl && !wdata[0];
    trig_done  = trig_q && (rem_q == '0);
    cap_wr     = (state_q == ST_RUN) && trc_valid && !trig_done && !cmd.wr_wdat;
    pad_wr     = ((state_q == ST_PAD) || (state_q == ST_FLUSH)) && !aligned && !cmd.wr_wdat;
    flush_set  = cmd.wr_fctrl && wdata[BIT_FLUSH];
    flush_done = flush_pend && ((state_q == ST_STOP) || ((state_q != ST_RUN) && aligned));

    state_d = state_q;
    case (state_q)
      ST_STOP: begin
        if (start) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (stop_req || trig_done) begin
          state_d = ST_PAD;
        end else if (flush_pend) begin
          state_d = stop_fl ? ST_PAD : ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (stop_req) begin
          state_d = ST_PAD;
        end else if (aligned) begin
          state_d = ST_RUN;
        end
      end
      ST_PAD: begin
        if (aligned) state_d = ST_STOP;
      end
      default: state_d = ST_STOP;
    endcase

    cap_en_d  = cmd.wr_ctrl  ? wdata[0]           : cap_en;
    fmt_d     = cmd.wr_fctrl ? wdata[BIT_FMT]     : fmt_en;
    stop_fl_d = cmd.wr_fctrl ? wdata[BIT_STOP_FL] : stop_fl;
    stop_tr_d = cmd.wr_fctrl ? wdata[BIT_STOP_TR] : stop_tr;
    tcnt_d    = cmd.wr_tcnt  ? wdata              : tcnt;

    flush_d = flush_pend;
    if (flush_done) flush_d = 1'b0;
    if (flush_set)  flush_d = 1'b1;

    trig_d = trig_q;
    rem_d  = rem_q;
    if (start) begin
      trig_d = 1'b0;
      rem_d  = '0;
    end else if ((state_q == ST_RUN) && trc_trigger && stop_tr && !trig_q) begin
      trig_d = 1'b1;
      rem_d  = tcnt;
    end else if (trig_q && cap_wr) begin
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_STOP;
      cap_en     <= 1'b0;
      fmt_en     <= 1'b0;
      stop_fl    <= 1'b0;
      stop_tr    <= 1'b0;
      tcnt       <= '0;
      flush_pend <= 1'b0;
      trig_q     <= 1'b0;
      rem_q      <= '0;
    end else begin
      state_q <= state_d;
      if (cmd.wr_ctrl) cap_en <= cap_en_d;
      if (cmd.wr_fctrl) begin
        fmt_en  <= fmt_d;
        stop_fl <= stop_fl_d;
        stop_tr <= stop_tr_d;
      end
      if (cmd.wr_tcnt) tcnt <= tcnt_d;
      if (flush_set || flush_done) flush_pend <= flush_d;
      trig_q <= trig_d;
      rem_q  <= rem_d;
    end
  end

  assign stopped = (state_q == ST_STOP);

endmodule

// File: rtl/trs_regbus.sv
module trs_regbus
  import trs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int PW    = $clog2(DEPTH),
  parameter int TRG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  output bus_cmd_t          cmd,
  input  logic [DW-1:0]     ram_q,
  input  logic              full,
  input  logic [PW-1:0]     rd_ptr,
  input  logic [PW-1:0]     wr_ptr,
  input  logic [TRG_W-1:0]  tcnt,
  input  logic              cap_en,
  input  logic              stopped,
  input  logic              fmt_en,
  input  logic              flush_pend,
  input  logic              stop_fl,
  input  logic              stop_tr,
  output logic [DW-1:0]     bus_rdata
);

  logic [DW-1:0] rd_val, rdata_d;

  always_comb begin
    cmd = '0;
    if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:  cmd.wr_ctrl  = 1'b1;
        OFS_FCTRL: cmd.wr_fctrl = 1'b1;
        OFS_TCNT:  cmd.wr_tcnt  = 1'b1;
        OFS_WPTR:  cmd.wr_wptr  = 1'b1;
        OFS_RPTR:  cmd.wr_rptr  = 1'b1;
        OFS_WDAT:  cmd.wr_wdat  = 1'b1;
        default:   ;
      endcase
    end
    cmd.rd_rdat = bus_rd && (bus_addr == OFS_RDAT);
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_DEPTH: rd_val = DW'(DEPTH);
      OFS_STAT:  rd_val[0] = full;
      OFS_RDAT:  rd_val = ram_q;
      OFS_RPTR:  rd_val[PW-1:0] = rd_ptr;
      OFS_WPTR:  rd_val[PW-1:0] = wr_ptr;
      OFS_TCNT:  rd_val[TRG_W-1:0] = tcnt;
      OFS_CTRL:  rd_val[0] = cap_en;
      OFS_FSTAT: rd_val[BIT_STOPPED] = stopped;
      OFS_FCTRL: begin
        rd_val[BIT_FMT]     = fmt_en;
        rd_val[BIT_FLUSH]   = flush_pend;
        rd_val[BIT_STOP_FL] = stop_fl;
        rd_val[BIT_STOP_TR] = stop_tr;
      end
      default:   rd_val = '0;
    endcase
    rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int DW          = 32,
  parameter int FRAME_WORDS = 4,
  parameter int TRG_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              trc_valid,
  input  logic [DW-1:0]     trc_data,
  input  logic              trc_trigger,
  output logic              trc_ready
);

  localparam int PW = $clog2(DEPTH);
  localparam int FB = $clog2(FRAME_WORDS);

  logic [1:0]    rst_sync;
  logic          rst_sync_n;
  bus_cmd_t      cmd;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, start, cap_wr, pad_wr, stopped, aligned;
  logic          cap_en, fmt_en, stop_fl, stop_tr, flush_pend, flush_set;
  logic [TRG_W-1:0] tcnt;
  logic          ram_we;
  logic [DW-1:0] ram_wdata, ram_q;
  logic          rrd_rd, rp_ld, wp_ld, rwd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  assign aligned = (wr_ptr[FB-1:0] == '0);
  assign ram_we  = cmd.wr_wdat || pad_wr || cap_wr;

  always_comb begin
    if (cmd.wr_wdat) begin
      ram_wdata = bus_wdata;
    end else if (pad_wr) begin
      ram_wdata = '0;
    end else begin
      ram_wdata = trc_data;
    end
  end

  assign rrd_rd    = cmd.rd_rdat;
  assign rp_ld     = cmd.wr_rptr;
  assign wp_ld     = cmd.wr_wptr;
  assign rwd_wr    = cmd.wr_wdat;
  assign trc_ready = 1'b1;

  trs_regbus #(.DEPTH(DEPTH), .DW(DW), .PW(PW), .TRG_W(TRG_W)) u_regbus (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .cmd(cmd), .ram_q(ram_q), .full(full),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .tcnt(tcnt), .cap_en(cap_en),
    .stopped(stopped), .fmt_en(fmt_en), .flush_pend(flush_pend),
    .stop_fl(stop_fl), .stop_tr(stop_tr), .bus_rdata(bus_rdata)
  );

  trs_ctrl #(.TRG_W(TRG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cmd(cmd), .wdata(bus_wdata[TRG_W-1:0]),
    .trc_valid(trc_valid), .trc_trigger(trc_trigger), .aligned(aligned),
    .start(start), .cap_wr(cap_wr), .pad_wr(pad_wr), .stopped(stopped),
    .cap_en(cap_en), .fmt_en(fmt_en), .stop_fl(stop_fl), .stop_tr(stop_tr),
    .flush_pend(flush_pend), .flush_set(flush_set), .tcnt(tcnt)
  );

  trs_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk(clk), .rst_n(rst_sync_n),
    .wp_load(cmd.wr_wptr), .wp_val(bus_wdata[PW-1:0]), .wr_adv(ram_we),
    .rp_load(cmd.wr_rptr), .rp_val(bus_wdata[PW-1:0]), .rd_adv(cmd.rd_rdat),
    .start(start), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full)
  );

  trs_ram #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(ram_wdata),
    .raddr(rd_ptr), .q(ram_q)
  );

endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int PW = 8,
  parameter int FB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stopped,
  input logic          full,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          flush_pend,
  input logic          flush_set,
  input logic          rrd_rd,
  input logic          rp_ld,
  input logic          wp_ld,
  input logic          rwd_wr
);

  AST_ALIGNED_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> (wr_ptr[FB-1:0] == '0)); // R6

  AST_NO_STORE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wp_ld && !rwd_wr) |=> $stable(wr_ptr)); // R7

  AST_START_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped) |-> !full); // R4

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && stopped && !flush_set) |=> !flush_pend); // R10

  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rrd_rd && !rp_ld) |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1))); // R3

endmodule

bind trace_ring_sink trs_checker #(.PW(PW), .FB(FB)) u_trs_checker (
  .clk(clk), .rst_n(rst_sync_n), .stopped(stopped), .full(full),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .flush_pend(flush_pend),
  .flush_set(flush_set), .rrd_rd(rrd_rd), .rp_ld(rp_ld), .wp_ld(wp_ld),
  .rwd_wr(rwd_wr)
);

// File: tb/test_trace_ring_sink.sv
`timescale 1ns/1ps
module test_trace_ring_sink;

  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
                          A_RPTR = 12'h014, A_WPTR = 12'h018, A_TCNT = 12'h01C,
                          A_CTRL = 12'h020, A_WDAT = 12'h024, A_FSTAT = 12'h300,
                          A_FCTRL = 12'h304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        trc_valid, trc_trigger, trc_ready;
  logic [31:0] trc_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_mem [256];
  int m_wp = 0;

  always #10 clk = ~clk;

  trace_ring_sink i_trace_ring_sink (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .trc_ready(trc_ready)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic void store(input logic [31:0] d);
    m_mem[m_wp] = d;
    m_wp = (m_wp + 1) % 256;
  endfunction

  function automatic void pad_model();
    while ((m_wp % 4) != 0) store(32'h0);
  endfunction

  task automatic stream(input int n, input int trig_idx, input bit limit, input int trg);
    int  after = 0;
    bit  seen = 0;
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
      end
      @(negedge clk);
      d = $urandom;
      trc_valid = 1'b1; trc_data = d; trc_trigger = (i == trig_idx);
      if (!seen) begin
        store(d);
        if (i == trig_idx && limit) seen = 1;
      end else if (after < trg) begin
        store(d);
        after++;
      end
    end
    @(negedge clk);
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic check_ram(input int start, input int cnt, input string req);
    logic [31:0] v;
    wr(A_RPTR, 32'(start));
    for (int i = 0; i < cnt; i++) begin
      rd(A_RDAT, v);
      chk(req, v, m_mem[(start + i) % 256]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    trc_valid = 1'b0; trc_trigger = 1'b0; trc_data = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state and depth register
    rd(A_DEPTH, v);
    chk("R1 depth", v, 32'd256);
    chk("R1 depth bit31", {31'd0, v[31]}, 32'd0);
    rd_chk(A_STAT, 32'h0, "R1 status");
    rd_chk(A_CTRL, 32'h0, "R1 control");
    rd_chk(A_FSTAT, 32'h2, "R1 flush status");
    rd_chk(A_FCTRL, 32'h0, "R1 flush control");
    rd_chk(A_WPTR, 32'h0, "R1 write pointer");

    // R2 fill the whole RAM through the write-data register
    wr(A_WPTR, 32'h0);
    for (int i = 0; i < 256; i++) begin
      d = $urandom;
      wr(A_WDAT, d);
      m_mem[i] = d;
    end
    m_wp = 0;
    rd_chk(A_WPTR, 32'h0, "R2 pointer wrapped");
    rd_chk(A_STAT, 32'h1, "R5 full after wrap");

    // R3 read port, wrap, upper pointer bits
    check_ram(0, 6, "R3");
    check_ram(254, 4, "R3 wrap");
    rd_chk(A_RPTR, 32'd2, "R3 read pointer wrapped");
    wr(A_RPTR, 32'hFFFF_FF05);
    rd_chk(A_RPTR, 32'd5, "R3 upper bits zero");

    // R4 start capture, R6 stop with padding
    wr(A_FCTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    rd_chk(A_STAT, 32'h0, "R4 full cleared");
    rd_chk(A_FSTAT, 32'h0, "R4 running");
    chk("R4 ready", {31'd0, trc_ready}, 32'd1);
    stream(10, -1, 0, 0);
    wr(A_CTRL, 32'h0);
    idle(6);
    pad_model();
    rd_chk(A_WPTR, 32'(m_wp), "R6 pointer aligned");
    rd_chk(A_FSTAT, 32'h2, "R6 stopped");
    check_ram(0, 10, "R4 stored words");
    check_ram(10, 2, "R6 zero padding");

    // R7 discard while stopped
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      trc_valid = 1'b1; trc_data = 32'hDEAD_0000 + 32'(i);
    end
    @(negedge clk);
    trc_valid = 1'b0;
    rd_chk(A_WPTR, 32'd12, "R7 pointer unchanged");
    check_ram(8, 4, "R7 contents unchanged");

    // R8 stop after trigger plus count
    wr(A_WPTR, 32'h0);
    m_wp = 0;
    wr(A_TCNT, 32'd5);
    wr(A_FCTRL, 32'h2001);
    wr(A_CTRL, 32'h1);
    stream(20, 3, 1, 5);
    idle(6);
    pad_model();
    rd_chk(A_WPTR, 32'(m_wp), "R8 stop point");
    rd_chk(A_FSTAT, 32'h2, "R8 stopped");
    rd_chk(A_FCTRL, 32'h2001, "R8 control readback");
    rd_chk(A_TCNT, 32'd5, "R8 count readback");
    check_ram(0, m_wp, "R8 contents");

    // R5 wrap during capture; R8 trigger ignored without stop-on-trigger
    wr(A_WPTR, 32'd250);
    m_wp = 250;
    wr(A_FCTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    rd_chk(A_STAT, 32'h0, "R4 full cleared on restart");
    stream(10, 4, 0, 0);
    idle(2);
    rd_chk(A_STAT, 32'h1, "R5 full on capture wrap");
    rd_chk(A_FSTAT, 32'h0, "R8 trigger ignored");
    rd_chk(A_WPTR, 32'd4, "R5 pointer after wrap");
    wr(A_CTRL, 32'h0);
    idle(6);
    rd_chk(A_WPTR, 32'd4, "R6 no pad when aligned");
    rd_chk(A_FSTAT, 32'h2, "R6 stopped aligned");
    check_ram(250, 10, "R5 contents across wrap");

    // R9 flush without stop
    wr(A_WPTR, 32'h0);
    m_wp = 0;
    wr(A_CTRL, 32'h1);
    stream(5, -1, 0, 0);
    wr(A_FCTRL, 32'h40);
    idle(8);
    pad_model();
    rd_chk(A_FCTRL, 32'h0, "R9 flush bit cleared");
    rd_chk(A_FSTAT, 32'h0, "R9 still running");
    stream(3, -1, 0, 0);
    idle(2);
    rd_chk(A_WPTR, 32'(m_wp), "R9 capture continues");
    check_ram(0, m_wp, "R9 contents");

    // R10 flush with stop
    wr(A_FCTRL, 32'h1040);
    idle(8);
    pad_model();
    rd_chk(A_FSTAT, 32'h2, "R10 stopped");
    rd_chk(A_FCTRL, 32'h1000, "R10 flush bit cleared");
    rd_chk(A_WPTR, 32'(m_wp), "R10 pointer aligned");
    check_ram(8, 4, "R10 padding");

    summary();
    $finish;
  end

endmodule